// File: doc/BRIEF.md
# Page Write Load Controller

This block sits behind a parallel memory bus whose strobes arrive with no relation to the system clock. It gathers byte writes into a 32-byte page buffer. It remembers which byte slots were written, and it decides when a loading burst is over. Each accepted write releases its strobe, and that release restarts a load timer. If the bus then stays quiet until the timer runs out, the controller pulses a commit request. It also raises busy and presents the page number, the slot mask and the buffered bytes to the program engine.

The program engine is outside this block. A simple model of it in the testbench merges only the masked slots into its page. When the engine has finished, it returns a one-cycle program-done pulse. That pulse clears the mask and the buffer and reopens the bus for writes. The bus control lines, address and data are resynchronised through two flops before any edge is detected. A strobe must stay active for a minimum number of clocks before it counts as a write.

Top module: `page_load_ctrl`

## Requirements
- R1: A write strobe is active only while chip-enable is low, write-enable is low and output-enable is high. Output-enable low or chip-enable high blocks the write, and on its own never starts a load.
- R2: The byte address is taken when the strobe becomes active, which is the later of the two enable falls. The data is taken when the strobe ends, which is the earlier of the two enable rises. An address change in the middle of a strobe has no effect.
- R3: Address bits 4..0 pick the byte slot. Slots may be loaded in any order. Mask bit i is 1 exactly when slot i was loaded, and data byte i sits at bits 8*i+7..8*i of the data output.
- R4: The page output carries address bits 12..5 captured at the start of the last accepted strobe of the burst.
- R5: Every strobe release restarts the timer. A strobe that becomes active before the timer runs out stops it and continues the same burst, so that burst gives exactly one commit.
- R6: When LOAD_TMO_CYC clocks pass after the last release with no active strobe, commit is high for exactly one clock and busy rises. Commit comes between LOAD_TMO_CYC-2 and LOAD_TMO_CYC+6 clocks after the write-enable rise.
- R7: At commit, the mask holds only the slots that were addressed. Every other slot's mask bit is 0, so the program engine leaves those bytes of the page unchanged.
- R8: A strobe that stays active for fewer than MIN_PULSE_CYC synchronised clocks is neither a write nor the start of a load.
- R9: While busy, strobes are ignored. A program-done pulse while busy clears busy, the mask and the buffer on the next clock.
- R10: A slot written more than once in one burst keeps its most recent data.
- R11: After reset, busy, commit and the mask are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_ce_n | input | 1 | Bus chip-enable, active low, asynchronous |
| bus_we_n | input | 1 | Bus write-enable, active low, asynchronous |
| bus_oe_n | input | 1 | Bus output-enable, active low, asynchronous |
| bus_addr | input | 13 | Bus address: bits 12..5 page, bits 4..0 slot |
| bus_data | input | 8 | Bus write data |
| prog_done | input | 1 | One-clock pulse from the program engine when it has finished |
| commit | output | 1 | One-clock request to program the buffered page |
| commit_page | output | 8 | Page number of the burst |
| commit_mask | output | 32 | One bit per loaded slot |
| commit_data | output | 256 | Buffered bytes, slot i at bits 8*i+7..8*i |
| busy | output | 1 | High from commit until program-done |

## Verification
The assertions assume that prog_done comes only as an isolated pulse. They also assume that address and data stay steady from before a strobe begins until at least two clocks after it ends, apart from the deliberate mid-strobe address change. The stimulus changes every bus pin only on the falling clock edge. It holds data for two clocks past each write-enable rise and raises the enables only after that. Apart from the glitch case, it keeps each strobe at least three clocks long. Bursts are separated by waiting for commit and issuing program-done, so the busy-freeze checks only ever see a steady program phase.

// File: rtl/plc_pkg.sv
// Shared types for the page write load controller.
// Assumes: nothing beyond a standard 1800-2017 compile.
package plc_pkg;

    // Load controller phases: no burst, collecting bytes, waiting for programming
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_BUSY = 2'd2
    } plc_state_e;

endpackage

// File: rtl/plc_sync.sv
// Two-flop resynchroniser for a bundle of asynchronous bus pins.
// Assumes: every bit of the bundle goes through the same delay, so
// control and data stay aligned to each other at the output.
module plc_sync #(
    parameter int          W       = 8,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    // Shift the pins through two stages
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            sync_q <= RST_VAL;
        end else begin
            meta_q <= d_i;
            sync_q <= meta_q;
        end
    end

    assign q_o = sync_q;

endmodule

// File: rtl/plc_strobe.sv
// Write-strobe qualifier: filters short pulses, latches the address
// when the strobe starts and reports its release with the data present then.
// Assumes: act_i, addr_i and data_i are already synchronised and aligned.
module plc_strobe #(
    parameter int ADDR_W        = 13,
    parameter int DATA_W        = 8,
    parameter int OFS_W         = 5,
    parameter int MIN_PULSE_CYC = 2,
    localparam int PAGE_W       = ADDR_W - OFS_W,
    localparam int CNT_W        = $clog2(MIN_PULSE_CYC + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              act_i,
    input  logic              block_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              start_o,
    output logic              armed_o,
    output logic              rel_o,
    output logic [PAGE_W-1:0] cap_page_o,
    output logic [OFS_W-1:0]  rel_idx_o,
    output logic [DATA_W-1:0] rel_data_o
);

    logic              act_prev_q;
    logic [CNT_W-1:0]  len_q;
    logic              armed_q;
    logic [ADDR_W-1:0] pend_addr_q;
    logic              rise;
    logic              qual_now;

    assign rise     = act_i && !act_prev_q;
    assign qual_now = act_i && (len_q == CNT_W'(MIN_PULSE_CYC - 1)) && !block_i;

    // Track the previous level and latch the address at the strobe start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_prev_q  <= 1'b0;
            pend_addr_q <= '0;
        end else begin
            act_prev_q <= act_i;
            if (rise) begin
                pend_addr_q <= addr_i;
            end
        end
    end

    // Count how long the strobe has been active, saturating at the threshold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q <= '0;
        end else if (!act_i) begin
            len_q <= '0;
        end else if (len_q < CNT_W'(MIN_PULSE_CYC)) begin
            len_q <= len_q + 1'b1;
        end
    end

    // A strobe becomes armed once it has lasted long enough and stays armed until it ends
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else if (qual_now) begin
            armed_q <= 1'b1;
        end else if (!act_i) begin
            armed_q <= 1'b0;
        end
    end

    assign start_o    = qual_now;
    assign armed_o    = armed_q;
    assign rel_o      = armed_q && !act_i;
    assign cap_page_o = rise ? addr_i[ADDR_W-1:OFS_W] : pend_addr_q[ADDR_W-1:OFS_W];
    assign rel_idx_o  = pend_addr_q[OFS_W-1:0];
    assign rel_data_o = data_i;

    AST_START_NEEDS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> act_i); // R8

    AST_NO_START_WHEN_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        block_i |-> !start_o); // R9

    generate
        if (MIN_PULSE_CYC >= 2) begin : g_glitch_chk
            AST_SHORT_PULSE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
                start_o |-> $past(act_i)); // R8
        end
    endgenerate

endmodule

// File: rtl/plc_page_buf.sv
// Page buffer: one data byte and one valid bit per slot, cleared as a whole.
// Assumes: wr_en_i and clr_i never need to act on the same slot in one clock
// (clearing wins).
module plc_page_buf #(
    parameter int DATA_W     = 8,
    parameter int OFS_W      = 5,
    localparam int SLOTS     = 1 << OFS_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en_i,
    input  logic [OFS_W-1:0]        idx_i,
    input  logic [DATA_W-1:0]       data_i,
    input  logic                    clr_i,
    output logic [SLOTS-1:0]        mask_o,
    output logic [SLOTS*DATA_W-1:0] data_o
);

    generate
        for (genvar g = 0; g < SLOTS; g++) begin : g_slot
            logic [DATA_W-1:0] byte_q;
            logic              vld_q;

            // Store the latest byte for this slot and mark it loaded
            always_ff @(posedge clk) begin
                if (!rst_n || clr_i) begin
                    byte_q <= '0;
                    vld_q  <= 1'b0;
                end else if (wr_en_i && (idx_i == OFS_W'(g))) begin
                    byte_q <= data_i;
                    vld_q  <= 1'b1;
                end
            end

            assign mask_o[g]                    = vld_q;
            assign data_o[g*DATA_W +: DATA_W]   = byte_q;
        end
    endgenerate

    AST_WRITE_MARKS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !clr_i) |=> (mask_o != '0)); // R3

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (mask_o == '0)); // R9

endmodule

// File: rtl/page_load_ctrl.sv
// Page write load controller: collects bus byte writes into a page buffer
// and requests a program cycle once the bus has stayed quiet for the load timeout.
// Assumes: prog_done is a single-clock pulse from the program engine; bus
// pins are asynchronous and are resynchronised here.
module page_load_ctrl #(
    parameter int ADDR_W        = 13,
    parameter int DATA_W        = 8,
    parameter int OFS_W         = 5,
    parameter int LOAD_TMO_CYC  = 64,
    parameter int MIN_PULSE_CYC = 2,
    localparam int PAGE_W       = ADDR_W - OFS_W,
    localparam int SLOTS        = 1 << OFS_W,
    localparam int TMR_W        = $clog2(LOAD_TMO_CYC + 1),
    localparam int BUS_W        = 3 + ADDR_W + DATA_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_ce_n,
    input  logic                    bus_we_n,
    input  logic                    bus_oe_n,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [DATA_W-1:0]       bus_data,
    input  logic                    prog_done,
    output logic                    commit,
    output logic [PAGE_W-1:0]       commit_page,
    output logic [SLOTS-1:0]        commit_mask,
    output logic [SLOTS*DATA_W-1:0] commit_data,
    output logic                    busy
);

    import plc_pkg::*;

    localparam logic [BUS_W-1:0]  BUS_RST = {3'b101, {(ADDR_W + DATA_W){1'b0}}};
    localparam logic [TMR_W-1:0]  TMO     = TMR_W'(LOAD_TMO_CYC);

    plc_state_e        state_q;
    logic [TMR_W-1:0]  tmr_q;
    logic              commit_q;
    logic [PAGE_W-1:0] page_q;

    logic [BUS_W-1:0]  bus_s;
    logic              ce_n_s, we_n_s, oe_n_s;
    logic [ADDR_W-1:0] addr_s;
    logic [DATA_W-1:0] data_s;
    logic              wr_act;

    logic              strb_start, strb_armed, strb_rel, strb_live;
    logic [PAGE_W-1:0] strb_page;
    logic [OFS_W-1:0]  strb_idx;
    logic [DATA_W-1:0] strb_data;
    logic              buf_wr, buf_clr;

    plc_sync #(
        .W       (BUS_W),
        .RST_VAL (BUS_RST)
    ) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({bus_ce_n, bus_we_n, bus_oe_n, bus_addr, bus_data}),
        .q_o   (bus_s)
    );

    assign {ce_n_s, we_n_s, oe_n_s, addr_s, data_s} = bus_s;
    assign wr_act = !ce_n_s && !we_n_s && oe_n_s;

    plc_strobe #(
        .ADDR_W        (ADDR_W),
        .DATA_W        (DATA_W),
        .OFS_W         (OFS_W),
        .MIN_PULSE_CYC (MIN_PULSE_CYC)
    ) strobe_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .act_i      (wr_act),
        .block_i    (state_q == ST_BUSY),
        .addr_i     (addr_s),
        .data_i     (data_s),
        .start_o    (strb_start),
        .armed_o    (strb_armed),
        .rel_o      (strb_rel),
        .cap_page_o (strb_page),
        .rel_idx_o  (strb_idx),
        .rel_data_o (strb_data)
    );

    assign strb_live = strb_armed || strb_start;
    assign buf_wr    = strb_rel && (state_q != ST_BUSY);
    assign buf_clr   = prog_done && (state_q == ST_BUSY);

    plc_page_buf #(
        .DATA_W (DATA_W),
        .OFS_W  (OFS_W)
    ) buf_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en_i (buf_wr),
        .idx_i   (strb_idx),
        .data_i  (strb_data),
        .clr_i   (buf_clr),
        .mask_o  (commit_mask),
        .data_o  (commit_data)
    );

    // Keep the page number of the latest accepted strobe start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_q <= '0;
        end else if (strb_start) begin
            page_q <= strb_page;
        end
    end

    // Burst sequencing: restart the timer on release, hold it during a strobe, commit on expiry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            tmr_q    <= '0;
            commit_q <= 1'b0;
        end else begin
            commit_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (strb_rel) begin
                        state_q <= ST_LOAD;
                        tmr_q   <= TMO;
                    end
                end
                ST_LOAD: begin
                    if (strb_rel) begin
                        tmr_q <= TMO;
                    end else if (strb_live) begin
                        tmr_q <= tmr_q;
                    end else if (tmr_q <= TMR_W'(1)) begin
                        state_q  <= ST_BUSY;
                        commit_q <= 1'b1;
                    end else begin
                        tmr_q <= tmr_q - 1'b1;
                    end
                end
                ST_BUSY: begin
                    if (prog_done) begin
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign commit      = commit_q;
    assign commit_page = page_q;
    assign busy        = (state_q == ST_BUSY);

    AST_COMMIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !commit); // R6

    AST_COMMIT_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> busy); // R6

    AST_COMMIT_HAS_BYTES: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (commit_mask != '0)); // R7

    AST_NO_COMMIT_MID_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> !strb_armed); // R5

    AST_BUSY_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !prog_done) |=> ($stable(commit_mask) && $stable(commit_data) && $stable(commit_page))); // R9

    AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && prog_done) |=> (!busy && (commit_mask == '0))); // R9

endmodule

// File: tb/page_load_ctrl_tb.sv
// Self-checking bench for page_load_ctrl with its default configuration.
module page_load_ctrl_tb_top;

    localparam int TMO = 64;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [12:0]  addr = '0;
    logic [7:0]   data = '0;
    logic         done = 1'b0;
    logic         commit, busy;
    logic [7:0]   cpage;
    logic [31:0]  cmask;
    logic [255:0] cdata;

    int n_chk = 0, n_fail = 0, n_commit = 0;
    logic [7:0]   snap_page;
    logic [31:0]  snap_mask;
    logic [255:0] snap_data;
    logic [7:0]   model [32];

    always #10 clk = ~clk;

    page_load_ctrl dut_i (
        .clk (clk), .rst_n (rst_n),
        .bus_ce_n (ce_n), .bus_we_n (we_n), .bus_oe_n (oe_n),
        .bus_addr (addr), .bus_data (data), .prog_done (done),
        .commit (commit), .commit_page (cpage), .commit_mask (cmask),
        .commit_data (cdata), .busy (busy)
    );

    // Snapshot the outputs whenever a commit is seen
    always @(negedge clk) begin
        if (commit) begin
            n_commit++;
            snap_page = cpage;
            snap_mask = cmask;
            snap_data = cdata;
        end
    end

    task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // WE-controlled byte write; the address moves in mid-strobe, which must not matter
    task automatic wr(input logic [12:0] a, input logic [7:0] d, input int low_cyc);
        @(negedge clk);
        addr = a; data = d; oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
        for (int i = 0; i < low_cyc; i++) begin
            @(negedge clk);
            if (i == 1) addr = a ^ 13'h1FFF;
        end
        addr = a;
        we_n = 1'b1;
        repeat (2) @(negedge clk);
        ce_n = 1'b1;
    endtask

    task automatic wait_commit(output int cyc);
        cyc = 0;
        while (!commit && cyc < 3 * TMO) begin
            @(negedge clk);
            cyc++;
        end
        @(negedge clk);
    endtask

    task automatic finish_prog();
        repeat (3) @(negedge clk);
        done = 1'b1;
        @(negedge clk);
        done = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
    end

    initial begin
        int cyc;
        int base;
        logic [31:0]  emask;
        logic [255:0] edata;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        chk("R11 busy after reset", {255'd0, busy}, 256'd0);
        chk("R11 mask after reset", {224'd0, cmask}, 256'd0);
        chk("R11 commit after reset", {255'd0, commit}, 256'd0);

        // R3 R2 R6: full pages written in scrambled slot order
        for (int p = 0; p < 4; p++) begin
            logic [7:0] pg;
            pg = (p == 0) ? 8'h00 : (p == 1) ? 8'h55 : (p == 2) ? 8'hAA : 8'hFF;
            base = n_commit;
            for (int i = 0; i < 32; i++) begin
                int s;
                s = (i * 7 + p) % 32;
                wr({pg, s[4:0]}, 8'(s * 13 + p * 29 + 1), 3);
            end
            wait_commit(cyc);
            edata = '0;
            for (int s = 0; s < 32; s++) edata[s*8 +: 8] = 8'(s * 13 + p * 29 + 1);
            chk("R5 one commit per burst", 256'(n_commit - base), 256'd1);
            chk("R3 full mask", {224'd0, snap_mask}, {224'd0, 32'hFFFF_FFFF});
            chk("R3 slot data", snap_data, edata);
            chk("R4 page number", {248'd0, snap_page}, {248'd0, pg});
            chk("R6 busy after commit", {255'd0, busy}, 256'd1);
            finish_prog();
            chk("R9 done clears busy", {255'd0, busy}, 256'd0);
            chk("R9 done clears mask", {224'd0, cmask}, 256'd0);
        end

        // R7: sparse slots only; the program model keeps the other bytes
        for (int s = 0; s < 32; s++) model[s] = 8'(8'hC0 + s);
        wr({8'h12, 5'd3}, 8'h33, 4);
        wr({8'h12, 5'd17}, 8'h71, 3);
        wr({8'h12, 5'd31}, 8'hF1, 5);
        wait_commit(cyc);
        chk("R7 sparse mask", {224'd0, snap_mask}, {224'd0, 32'h8002_0008});
        for (int s = 0; s < 32; s++) if (snap_mask[s]) model[s] = snap_data[s*8 +: 8];
        begin
            logic ok;
            ok = 1'b1;
            for (int s = 0; s < 32; s++) begin
                logic [7:0] e;
                e = (s == 3) ? 8'h33 : (s == 17) ? 8'h71 : (s == 31) ? 8'hF1 : 8'(8'hC0 + s);
                if (model[s] !== e) ok = 1'b0;
            end
            chk("R7 untouched bytes kept", {255'd0, ok}, 256'd1);
        end
        finish_prog();

        // R4 R10: page follows the last strobe, a rewritten slot keeps its last data
        wr({8'h05, 5'd9}, 8'h11, 3);
        wr({8'h05, 5'd9}, 8'h22, 3);
        wr({8'h09, 5'd1}, 8'h44, 3);
        wait_commit(cyc);
        chk("R4 last page wins", {248'd0, snap_page}, {248'd0, 8'h09});
        chk("R10 latest data kept", {248'd0, snap_data[9*8 +: 8]}, {248'd0, 8'h22});
        chk("R10 mask after rewrite", {224'd0, snap_mask}, {224'd0, 32'h0000_0202});
        finish_prog();

        // R1: output-enable low and chip-enable high block the strobe
        base = n_commit;
        @(negedge clk); addr = 13'h0004; data = 8'hEE; ce_n = 0; oe_n = 0; we_n = 0;
        repeat (5) @(negedge clk); we_n = 1; ce_n = 1; oe_n = 1;
        @(negedge clk); addr = 13'h0006; ce_n = 1; we_n = 0;
        repeat (5) @(negedge clk); we_n = 1;
        repeat (TMO + 20) @(negedge clk);
        chk("R1 blocked strobes start nothing", {255'd0, busy}, 256'd0);
        chk("R1 blocked strobes no commit", 256'(n_commit - base), 256'd0);
        wr(13'h0007, 8'h5A, 3);
        wait_commit(cyc);
        chk("R1 only enabled slot loaded", {224'd0, snap_mask}, {224'd0, 32'h0000_0080});
        finish_prog();

        // R8: a one-clock strobe is ignored
        base = n_commit;
        @(negedge clk); addr = 13'h0002; data = 8'h99; ce_n = 0; oe_n = 1; we_n = 0;
        @(negedge clk); we_n = 1;
        repeat (2) @(negedge clk); ce_n = 1;
        repeat (TMO + 20) @(negedge clk);
        chk("R8 glitch ignored", {224'd0, cmask, 255'd0} >> 255, 256'd0);
        chk("R8 glitch no commit", 256'(n_commit - base), 256'd0);

        // R5 R6: a write just before expiry keeps the burst open; commit timing
        base = n_commit;
        wr({8'h30, 5'd0}, 8'hA1, 3);
        repeat (TMO - 12) @(negedge clk);
        chk("R5 no commit before timeout", 256'(n_commit - base), 256'd0);
        wr({8'h30, 5'd1}, 8'hA2, 3);
        wait_commit(cyc);
        chk("R5 extended burst one commit", 256'(n_commit - base), 256'd1);
        chk("R5 both bytes in burst", {224'd0, snap_mask}, {224'd0, 32'h0000_0003});
        chk("R6 commit timing window", {255'd0, (cyc >= TMO - 2) && (cyc <= TMO + 6)}, 256'd1);
        @(negedge clk);
        chk("R6 commit one clock", {255'd0, commit}, 256'd0);

        // R9: strobes while busy are ignored
        emask = cmask;
        wr({8'h31, 5'd20}, 8'hBB, 4);
        chk("R9 mask frozen while busy", {224'd0, cmask}, {224'd0, emask});
        finish_prog();
        base = n_commit;
        repeat (TMO + 20) @(negedge clk);
        chk("R9 busy write not committed", 256'(n_commit - base), 256'd0);

        // R2: chip-enable controlled write, address at the later fall, data at the earlier rise
        @(negedge clk); addr = 13'h1FE0; data = 8'h00; oe_n = 1; we_n = 0; ce_n = 1;
        @(negedge clk); addr = {8'h44, 5'd12}; data = 8'h6C;
        @(negedge clk); ce_n = 0;
        repeat (2) @(negedge clk); addr = {8'h66, 5'd2};
        @(negedge clk); ce_n = 1;
        repeat (2) @(negedge clk); data = 8'h00; we_n = 1;
        wait_commit(cyc);
        chk("R2 slot from later fall", {224'd0, snap_mask}, {224'd0, 32'h0000_1000});
        chk("R2 data at earlier rise", {248'd0, snap_data[12*8 +: 8]}, {248'd0, 8'h6C});
        chk("R2 page from later fall", {248'd0, snap_page}, {248'd0, 8'h44});
        finish_prog();

        summary();
    end

endmodule